// File: doc/BRIEF.md
# Variable Fractional Delay Line

This block delays a stream of signed 16-bit samples by a delay that is set at run time with sub-sample resolution. Each accepted sample is stored in a circular buffer. The buffer is never shifted: the delay only moves the read position relative to the write position.

The output is built from four neighbouring stored samples. They are combined with third-order Lagrange interpolation weights, which the hardware computes from the fractional part of the delay on every sample. The interpolation point is D = 1 + f, where f is the fraction. The total delay is therefore `dly_int + 1 + dly_frac/4096` samples.

The weighted sum is rounded and clamped to 16 bits. It leaves the block five clock cycles after the sample that produced it.

Top module: `frac_delay_line`

## Requirements
- R1: While reset is held and directly after it, `out_valid` is 0 and `out_sample` is 0.
- R2: An accepted input (`in_valid` high at a rising edge) whose output is permitted raises `out_valid` for exactly one cycle, five rising edges later. With no accepted input, no output appears.
- R3: Number the accepted inputs n = 0, 1, … from reset, and let M be the clamped integer delay captured with input n. That input produces an output only if n ≥ M + 3.
- R4: When `dly_frac` is 0, the output for input n equals the sample accepted at index n − M − 1, with no error.
- R5: For a fraction f = `dly_frac`/4096 and D = 1 + f, the output equals round(Σ h_k·x[n−M−k]) for k = 0..3, to within ±2 LSB. The weights are h0 = −(D−1)(D−2)(D−3)/6, h1 = D(D−2)(D−3)/2, h2 = −D(D−1)(D−3)/2 and h3 = D(D−1)(D−2)/6.
- R6: With the default 256-entry buffer, an integer delay request above 252 acts exactly as 252.
- R7: Results above 32767 give 32767, and results below −32768 give −32768.
- R8: `dly_int` and `dly_frac` are sampled only with an accepted input. Values driven while `in_valid` is low have no effect on any output.
- R9: While `out_valid` is low, `out_sample` keeps its last value.
- R10: The four weights sum to unity, so a constant input yields the same constant at the output for any fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_sample` and the delay inputs |
| in_sample | input | 16 | Input sample, two's complement |
| dly_int | input | 10 | Integer delay request in samples |
| dly_frac | input | 12 | Fractional delay, unsigned, in units of 1/4096 sample |
| out_valid | output | 1 | Qualifies `out_sample` |
| out_sample | output | 16 | Interpolated, rounded and saturated output |

## Verification
A write pointer that slips, or a read base computed off by one, shows up at once as an output taken from the wrong sample. This is visible on the first valid output five cycles later, and it is caught exactly whenever the fraction is zero. A bad weight term or a swapped tap order appears as an error of many LSB as soon as a nonzero fraction meets non-constant data. A wrong fill count or a broken valid pipeline moves or suppresses `out_valid` pulses within the first few samples after reset. Clamp and saturation faults only appear under their specific stimulus, so directed runs with a delay request of 1023 and full-scale alternating data cover them.

// File: rtl/frac_delay_line.sv
`timescale 1ns/1ps
module frac_delay_line #(
  parameter int DW = 16,
  parameter int IW = 10,
  parameter int FW = 12,
  parameter int AW = 8,
  parameter int CF = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic [IW-1:0]        dly_int,
  input  logic [FW-1:0]        dly_frac,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample
);
  localparam int DEPTH = 1 << AW;
  localparam int MAXD  = DEPTH - 4;
  localparam int ONE   = 1 << FW;
  localparam int SW    = FW + 3;
  localparam int PW    = 2 * SW;
  localparam int QW    = 3 * SW;
  localparam int XW    = QW + 19;
  localparam int SH    = 3 * FW - CF;
  localparam int K6    = (1 << 18) / 6 + 1;
  localparam int HW    = CF + 4;
  localparam int MW    = DW + HW;
  localparam int AccW  = MW + 2;
  localparam int HALF  = 1 << (CF - 1);
  localparam int SMAX  = (1 << (DW - 1)) - 1;
  localparam int SMIN  = -(1 << (DW - 1));
  localparam int ONEC  = 1 << CF;

  logic [AW-1:0] wptr, rbase, mc;
  logic [AW:0]   fill;
  logic [FW-1:0] fa, fb, fc;
  logic          sa, sb, sc, sd;

  assign mc = (int'(dly_int) > MAXD) ? AW'(MAXD) : AW'(dly_int);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr  <= '0;
      rbase <= '0;
      fill  <= '0;
      fa    <= '0;
    end else if (in_valid) begin
      wptr  <= wptr + AW'(1);
      rbase <= wptr - mc;
      fa    <= dly_frac;
      if (fill != (AW+1)'(DEPTH)) fill <= fill + (AW+1)'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sa, sb, sc, sd, out_valid} <= '0;
    else begin
      sa        <= in_valid && (int'(fill) >= int'(mc) + 3);
      sb        <= sa;
      sc        <= sb;
      sd        <= sc;
      out_valid <= sd;
    end

  // weight generation, stage 1: pairwise products of (f-1)f and (f+1)(f-2)
  logic signed [SW-1:0] fsa, m1a, m2a, p1a;
  logic signed [PW-1:0] u_b, w_b;
  assign fsa = $signed({3'b000, fa});
  assign m1a = fsa - SW'(ONE);
  assign m2a = fsa - SW'(2 * ONE);
  assign p1a = fsa + SW'(ONE);

  always_ff @(posedge clk) begin
    u_b <= PW'(fsa) * PW'(m1a);
    w_b <= PW'(p1a) * PW'(m2a);
    fb  <= fa;
    fc  <= fb;
  end

  // stage 2: third factor, then scale by 1/6 or 1/2 into Q(CF)
  logic signed [SW-1:0] fsb, m1b, m2b, p1b;
  logic signed [QW-1:0] p0, p1, p2, p3, t0, t3;
  logic signed [XW-1:0] x0, x3;
  logic [3:0][HW-1:0]   h_c;
  assign fsb = $signed({3'b000, fb});
  assign m1b = fsb - SW'(ONE);
  assign m2b = fsb - SW'(2 * ONE);
  assign p1b = fsb + SW'(ONE);
  assign p0  = QW'(u_b) * QW'(m2b);
  assign p3  = QW'(u_b) * QW'(p1b);
  assign p1  = QW'(w_b) * QW'(m1b);
  assign p2  = QW'(w_b) * QW'(fsb);
  assign t0  = p0 >>> SH;
  assign t3  = p3 >>> SH;
  assign x0  = XW'(t0) * XW'(K6);
  assign x3  = XW'(t3) * XW'(K6);

  always_ff @(posedge clk) begin
    h_c[0] <= HW'(-(x0 >>> 18));
    h_c[1] <= HW'(p1 >>> (SH + 1));
    h_c[2] <= HW'(-(p2 >>> (SH + 1)));
    h_c[3] <= HW'(x3 >>> 18);
  end

  // four memory banks, one per tap, each written with every sample
  logic [3:0][MW-1:0] prod;
  for (genvar k = 0; k < 4; k++) begin : g_tap
    logic signed [DW-1:0] mem [DEPTH];
    logic signed [DW-1:0] rd_b, rd_c;
    always_ff @(posedge clk) begin
      if (in_valid) mem[wptr] <= in_sample;
      rd_b <= mem[rbase - AW'(k)];
      rd_c <= rd_b;
    end
    assign prod[k] = MW'(rd_c) * MW'($signed(h_c[k]));
  end

  logic signed [AccW-1:0] acc_d, rsh;
  always_ff @(posedge clk)
    acc_d <= AccW'($signed(prod[0])) + AccW'($signed(prod[1]))
           + AccW'($signed(prod[2])) + AccW'($signed(prod[3]));

  assign rsh = (acc_d + AccW'(HALF)) >>> CF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_sample <= '0;
    else if (sd)
      out_sample <= (rsh > AccW'(SMAX)) ? DW'(SMAX) :
                    (rsh < AccW'(SMIN)) ? DW'(SMIN) : DW'(rsh);

  logic signed [HW+1:0] hsum;
  assign hsum = (HW+2)'($signed(h_c[0])) + (HW+2)'($signed(h_c[1]))
              + (HW+2)'($signed(h_c[2])) + (HW+2)'($signed(h_c[3]));

  AST_WEIGHT_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    sc |-> (hsum > (HW+2)'(ONEC - 16)) && (hsum < (HW+2)'(ONEC + 16))); // R10
  AST_INTEGER_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sc && fc == '0) |-> (h_c[1] == HW'(ONEC)) && (h_c[0] == '0) && (h_c[2] == '0) && (h_c[3] == '0)); // R4
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 5)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_sample)); // R9
endmodule

// File: tb/frac_delay_line_tb.sv
`timescale 1ns/1ps
module frac_delay_line_tb;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic [9:0]  dly_int = '0;
  logic [11:0] dly_frac = '0;
  logic        out_valid;
  logic signed [15:0] out_sample;

  always #2 clk = ~clk;

  frac_delay_line u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .dly_int(dly_int), .dly_frac(dly_frac), .out_valid(out_valid), .out_sample(out_sample));

  int checks = 0, fails = 0, k = 0, n = 0;
  bit done = 1'b0;
  int hist [512];
  bit sv [8];
  int se [8];
  int stol [8];
  string st [8];
  logic signed [15:0] prev_out = '0;

  function automatic real lw(int idx, real f);
    real d;
    d = 1.0 + f;
    case (idx)
      0: return -(d - 1.0) * (d - 2.0) * (d - 3.0) / 6.0;
      1: return d * (d - 2.0) * (d - 3.0) / 2.0;
      2: return -d * (d - 1.0) * (d - 3.0) / 2.0;
      default: return d * (d - 1.0) * (d - 2.0) / 6.0;
    endcase
  endfunction

  task automatic step(input bit v, input int x, input int di, input int df, input string tag);
    int s, t, mc, e, diff;
    real y;
    string tg;
    @(negedge clk);
    s = k % 8;
    if (sv[s] || out_valid) begin
      checks++;
      if (out_valid !== sv[s]) begin
        fails++;
        $display("FAIL %s: out_valid=%0b expected %0b", sv[s] ? "R2" : "R3", out_valid, sv[s]);
      end else begin
        diff = int'(out_sample) - se[s];
        if (diff < 0) diff = -diff;
        if (diff > stol[s]) begin
          fails++;
          $display("FAIL %s: out_sample=%0d expected %0d", st[s], out_sample, se[s]);
        end
      end
    end
    if (!out_valid) begin
      checks++;
      if (out_sample !== prev_out) begin
        fails++;
        $display("FAIL R9: out_sample=%0d expected held %0d", out_sample, prev_out);
      end
    end
    prev_out = out_sample;
    sv[s] = 1'b0;
    in_valid = v; in_sample = 16'(x); dly_int = 10'(di); dly_frac = 12'(df);
    if (v) begin
      mc = (di > 252) ? 252 : di;
      hist[n % 512] = x;
      if (n >= mc + 3) begin
        y = 0.0;
        for (int kk = 0; kk < 4; kk++) y += lw(kk, df / 4096.0) * hist[(n - mc - kk) % 512];
        tg = tag;
        if (di > 252) tg = "R6";
        if (y > 32767.0 || y < -32768.0) tg = "R7";
        e = int'(y);
        if (e > 32767) e = 32767;
        if (e < -32768) e = -32768;
        t = (k + 5) % 8;
        sv[t] = 1'b1; se[t] = e; stol[t] = (df == 0) ? 0 : 2; st[t] = tg;
      end
      n++;
    end
    k++;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin sv[i] = 1'b0; se[i] = 0; stol[i] = 0; st[i] = "R2"; end
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R1");
    checks++;
    if (out_valid !== 1'b0 || out_sample !== 16'sd0) begin
      fails++;
      $display("FAIL R1: out_valid=%0b out_sample=%0d expected 0 0", out_valid, out_sample);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R1");
    checks++;
    if (out_valid !== 1'b0 || out_sample !== 16'sd0) begin
      fails++;
      $display("FAIL R1: after release out_valid=%0b out_sample=%0d expected 0 0", out_valid, out_sample);
    end
    // R4: integer delays, exact
    for (int i = 0; i < 60; i++) step(1, i * 517 - 15000, 2, 0, "R4");
    for (int i = 0; i < 20; i++) step(1, i * 1111 - 9000, 0, 0, "R4");
    // R5: fixed fraction
    for (int i = 0; i < 80; i++) step(1, int'($urandom % 65536) - 32768, 5, 1024, "R5");
    // R6: clamp of oversized request
    for (int i = 0; i < 300; i++) step(1, int'($urandom % 65536) - 32768, 1023, 0, "R6");
    for (int i = 0; i < 40; i++) step(1, int'($urandom % 65536) - 32768, 1000, 3000, "R6");
    // R7: full-scale alternating pattern, half-sample fraction
    for (int i = 0; i < 40; i++)
      step(1, ((i % 4) == 0 || (i % 4) == 3) ? -32768 : 32767, 0, 2048, "R5");
    // R8: delay inputs wiggle only while idle
    for (int r = 0; r < 12; r++) begin
      for (int j = 0; j < 3; j++) step(0, 7, int'($urandom % 1024), int'($urandom % 4096), "R8");
      step(1, int'($urandom % 65536) - 32768, 3, 777, "R8");
    end
    // R10: constant input, random fraction
    for (int i = 0; i < 100; i++) step(1, 12345, 10, int'($urandom % 4096), "R10");
    for (int i = 0; i < 100; i++) step(1, -20000, 10, int'($urandom % 4096), "R10");
    // random mix, delay changes every cycle
    for (int i = 0; i < 3000; i++)
      step(($urandom % 10) < 7, int'($urandom % 65536) - 32768,
           int'($urandom % 300), int'($urandom % 4096), "R5");
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, "R9");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule